// File: doc/BRIEF.md
# Word FIFO bridge with flush and data-request triggers

The block sits between a simple register bus and a byte-serial engine. It holds two 8-entry FIFOs of 32-bit words. The transmit FIFO is loaded by register writes. Its words are split into bytes for the engine, lowest byte first. The receive FIFO collects bytes from the engine, packs them into words lowest byte first, and software reads those words back.

A control register sets two trigger thresholds. The block drives a transmit data request when enough slots are free, and a receive data request when enough words are waiting. The control register also starts a flush of either FIFO. A flush empties the FIFO one entry per cycle, and its control bit reads 1 until the FIFO is empty. A status register reports the number of free transmit slots and the number of filled receive words.

The engine side uses valid/ready streams. On the transmit side, the block holds a byte and its data until the engine accepts it with `txb_ready`. On the receive side, the engine must hold `rxb_valid` and its byte until `rxb_ready` is high. A byte is taken only in a cycle where both signals are high.

Top module: `word_fifo_bridge`

## Requirements
- R1: After reset both FIFOs are empty, no flush is pending and both trigger codes are 0. Status reads 0x80 and control reads 0.
- R2: Register select 0 is control, 1 is status, 2 is transmit data (write) and 3 is receive data (read). Control bits 7:5 hold the transmit trigger code and bits 4:2 hold the receive trigger code. Both codes are written and read back.
- R3: Status bits 7:4 give 8 minus the transmit FIFO entries, and bits 3:0 give the receive FIFO entries. A transmit data write while the FIFO holds 8 entries is dropped, and `tx_ovf` pulses for one cycle in the next cycle.
- R4: A transmit word is sent as byte lanes 7:0, 15:8, 23:16 and 31:24, in that order. A word is loaded from the FIFO only when no word is held. While `txb_valid` is high and `txb_ready` is low, `txb_valid` and `txb_data` stay unchanged.
- R5: Received bytes fill lanes 0 to 3 in order. A word is pushed after the fourth byte, or earlier when a byte carries `rxb_last`. Lanes not filled are zero.
- R6: `rxb_ready` is low while the receive FIFO holds 8 words or a receive flush is pending.
- R7: A receive data read with the receive FIFO empty returns 0 and leaves the FIFO unchanged. `rx_unf` pulses in the next cycle.
- R8: Writing 1 to control bit 1 (transmit) or bit 0 (receive) starts a flush. The flush removes one entry per cycle, and the bit reads 1 until a cycle finds the FIFO empty. The bit then clears at the next edge. A flush also discards the word being sent or the bytes being packed. Writing 0 to these bits has no effect.
- R9: While a transmit flush is pending, `txb_valid` is low and transmit data writes are dropped with no overflow. While a receive flush is pending, receive data reads return 0, pop nothing and raise no underflow.
- R10: `tx_req` is high while the free transmit slots are at least the transmit code plus 1. `rx_req` is high while the filled receive words are at least the receive code plus 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops receive data) |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the selected register (combinational) |
| txb_valid | output | 1 | Transmit byte valid |
| txb_ready | input | 1 | Engine accepts the transmit byte |
| txb_data | output | 8 | Transmit byte |
| rxb_valid | input | 1 | Receive byte valid |
| rxb_ready | output | 1 | Block can take a receive byte |
| rxb_data | input | 8 | Receive byte |
| rxb_last | input | 1 | Byte is the last of its packet |
| tx_req | output | 1 | Transmit data request |
| rx_req | output | 1 | Receive data request |
| tx_ovf | output | 1 | Transmit overflow pulse |
| rx_unf | output | 1 | Receive underflow pulse |

## Verification
The assertions assume that `bus_wr` and `bus_rd` are never high in the same cycle. They assume that a flush starts only through a control write. They also assume that the engine drives `rxb_valid` and `txb_ready` as plain levels that are sampled at the clock edge.

The bench drives every input shortly after the falling edge and keeps at most one bus strobe per cycle. Its random phase mixes transmit and receive traffic with flushes and trigger changes. In that phase the ready and valid lines are toggled freely, so stalls and flushes in the middle of a word are both reached.

// File: rtl/wfb_pkg.sv
package wfb_pkg;
  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_STAT = 2'd1,
    REG_TXD  = 2'd2,
    REG_RXD  = 2'd3
  } reg_sel_e;
  localparam int CTL_RXFL  = 0;
  localparam int CTL_TXFL  = 1;
  localparam int CTL_RXTRG = 2;
  localparam int CTL_TXTRG = 5;
  localparam int STAT_FW   = 4;
endpackage

// File: rtl/wfb_fifo.sv
module wfb_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush_req,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          flushing
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  // a pending flush drains one entry per cycle and blocks all pushes
  assign do_pop  = (flushing | pop) & (count != '0);
  assign do_push = ~flushing & push & (count != CW'(DEPTH));
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr   <= '0;
      wr_ptr   <= '0;
      count    <= '0;
      flushing <= 1'b0;
    end else begin
      if (do_push) wr_ptr <= wrap_inc(wr_ptr);
      if (do_pop)  rd_ptr <= wrap_inc(rd_ptr);
      count <= count + CW'(do_push) - CW'(do_pop);
      if (flush_req)                      flushing <= 1'b1;
      else if (flushing && count == '0)   flushing <= 1'b0;
    end
  end
endmodule

// File: rtl/wfb_unpack.sv
module wfb_unpack #(
  parameter int W  = 32,
  parameter int BW = 8,
  localparam int NB = W / BW,
  localparam int IW = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flushing,
  input  logic          avail,
  input  logic [W-1:0]  word_in,
  output logic          load,
  output logic          txb_valid,
  input  logic          txb_ready,
  output logic [BW-1:0] txb_data
);
  logic          held;
  logic [W-1:0]  cur;
  logic [IW-1:0] idx;

  assign load      = ~held & ~flushing & avail;
  assign txb_valid = held & ~flushing;
  assign txb_data  = cur[BW*int'(idx) +: BW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held <= 1'b0;
      cur  <= '0;
      idx  <= '0;
    end else if (flushing) begin
      held <= 1'b0;
    end else if (held) begin
      if (txb_ready) begin
        if (idx == IW'(NB - 1)) held <= 1'b0;
        idx <= idx + IW'(1);
      end
    end else if (avail) begin
      cur  <= word_in;
      held <= 1'b1;
      idx  <= '0;
    end
  end
endmodule

// File: rtl/wfb_pack.sv
module wfb_pack #(
  parameter int W  = 32,
  parameter int BW = 8,
  localparam int NB = W / BW,
  localparam int IW = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flushing,
  input  logic          room,
  input  logic          rxb_valid,
  output logic          rxb_ready,
  input  logic [BW-1:0] rxb_data,
  input  logic          rxb_last,
  output logic          push,
  output logic [W-1:0]  word
);
  logic [W-1:0]  acc;
  logic [IW-1:0] nb;
  logic          take;

  assign rxb_ready = ~flushing & room;
  assign take      = rxb_valid & rxb_ready;
  assign word      = acc | (W'(rxb_data) << (BW * int'(nb)));
  assign push      = take & ((nb == IW'(NB - 1)) | rxb_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
      nb  <= '0;
    end else if (flushing) begin
      acc <= '0;
      nb  <= '0;
    end else if (take) begin
      if (push) begin
        acc <= '0;
        nb  <= '0;
      end else begin
        acc <= word;
        nb  <= nb + IW'(1);
      end
    end
  end
endmodule

// File: rtl/word_fifo_bridge.sv
module word_fifo_bridge
  import wfb_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int W     = 32,
  parameter int BW    = 8,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int TW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [1:0]    bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  output logic          txb_valid,
  input  logic          txb_ready,
  output logic [BW-1:0] txb_data,
  input  logic          rxb_valid,
  output logic          rxb_ready,
  input  logic [BW-1:0] rxb_data,
  input  logic          rxb_last,
  output logic          tx_req,
  output logic          rx_req,
  output logic          tx_ovf,
  output logic          rx_unf
);
  logic [TW-1:0] trig_tx, trig_rx;
  logic [CW-1:0] tx_cnt, rx_cnt, tx_free;
  logic          tx_flushing, rx_flushing;
  logic [W-1:0]  tx_head, rx_head, rx_word;
  logic          tx_load, rx_push;
  logic          ctrl_wr, txd_wr, rxd_rd;

  assign ctrl_wr = bus_wr & (bus_addr == REG_CTRL);
  assign txd_wr  = bus_wr & (bus_addr == REG_TXD);
  assign rxd_rd  = bus_rd & (bus_addr == REG_RXD);

  wfb_fifo #(.W(W), .DEPTH(DEPTH)) u_txf (
    .clk(clk), .rst_n(rst_n),
    .flush_req(ctrl_wr & bus_wdata[CTL_TXFL]),
    .push(txd_wr), .din(bus_wdata),
    .pop(tx_load), .dout(tx_head),
    .count(tx_cnt), .flushing(tx_flushing)
  );

  wfb_fifo #(.W(W), .DEPTH(DEPTH)) u_rxf (
    .clk(clk), .rst_n(rst_n),
    .flush_req(ctrl_wr & bus_wdata[CTL_RXFL]),
    .push(rx_push), .din(rx_word),
    .pop(rxd_rd), .dout(rx_head),
    .count(rx_cnt), .flushing(rx_flushing)
  );

  wfb_unpack #(.W(W), .BW(BW)) u_unpack (
    .clk(clk), .rst_n(rst_n), .flushing(tx_flushing),
    .avail(tx_cnt != '0), .word_in(tx_head), .load(tx_load),
    .txb_valid(txb_valid), .txb_ready(txb_ready), .txb_data(txb_data)
  );

  wfb_pack #(.W(W), .BW(BW)) u_pack (
    .clk(clk), .rst_n(rst_n), .flushing(rx_flushing),
    .room(rx_cnt != CW'(DEPTH)),
    .rxb_valid(rxb_valid), .rxb_ready(rxb_ready),
    .rxb_data(rxb_data), .rxb_last(rxb_last),
    .push(rx_push), .word(rx_word)
  );

  assign tx_free = CW'(DEPTH) - tx_cnt;
  assign tx_req  = tx_free >= (CW'(trig_tx) + CW'(1));
  assign rx_req  = rx_cnt  >= (CW'(trig_rx) + CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_tx <= '0;
      trig_rx <= '0;
      tx_ovf  <= 1'b0;
      rx_unf  <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        trig_tx <= bus_wdata[CTL_TXTRG +: TW];
        trig_rx <= bus_wdata[CTL_RXTRG +: TW];
      end
      tx_ovf <= txd_wr & ~tx_flushing & (tx_cnt == CW'(DEPTH));
      rx_unf <= rxd_rd & ~rx_flushing & (rx_cnt == '0);
    end
  end

  always_comb begin
    case (bus_addr)
      REG_CTRL: bus_rdata = W'({trig_tx, trig_rx, tx_flushing, rx_flushing});
      REG_STAT: bus_rdata = W'({STAT_FW'(tx_free), STAT_FW'(rx_cnt)});
      REG_RXD:  bus_rdata = (rx_flushing || rx_cnt == '0) ? '0 : rx_head;
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/wfb_checks.sv
module wfb_checks #(
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic [1:0]    bus_addr,
  input logic [31:0]   bus_wdata,
  input logic          txb_valid,
  input logic          txb_ready,
  input logic [7:0]    txb_data,
  input logic          rxb_ready,
  input logic          tx_req,
  input logic          tx_ovf,
  input logic          rx_unf,
  input logic [CW-1:0] tx_cnt,
  input logic [CW-1:0] rx_cnt,
  input logic          tx_flushing
);
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= CW'(DEPTH));

  assert_ovf_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ovf |-> $past(bus_wr && bus_addr == 2'd2 && tx_cnt == CW'(DEPTH)));

  assert_tx_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (txb_valid && !txb_ready && !(bus_wr && bus_addr == 2'd0 && bus_wdata[1]))
      |=> (txb_valid && $stable(txb_data)));

  assert_rx_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt == CW'(DEPTH)) |-> !rxb_ready);

  assert_unf_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_unf |-> $past(bus_rd && bus_addr == 2'd3 && rx_cnt == '0));

  assert_flush_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_flushing && tx_cnt == '0 && !(bus_wr && bus_addr == 2'd0 && bus_wdata[1]))
      |=> !tx_flushing);

  assert_treq_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt == '0) |-> tx_req);
endmodule

bind word_fifo_bridge wfb_checks #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .txb_valid(txb_valid), .txb_ready(txb_ready), .txb_data(txb_data),
  .rxb_ready(rxb_ready), .tx_req(tx_req), .tx_ovf(tx_ovf), .rx_unf(rx_unf),
  .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .tx_flushing(tx_flushing)
);

// File: tb/word_fifo_bridge_tb.sv
module word_fifo_bridge_tb;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        txb_valid, txb_ready = 1'b0;
  logic [7:0]  txb_data;
  logic        rxb_valid = 1'b0, rxb_ready, rxb_last = 1'b0;
  logic [7:0]  rxb_data = '0;
  logic        tx_req, rx_req, tx_ovf, rx_unf;

  always #5 clk = ~clk;

  word_fifo_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .txb_valid(txb_valid), .txb_ready(txb_ready), .txb_data(txb_data),
    .rxb_valid(rxb_valid), .rxb_ready(rxb_ready), .rxb_data(rxb_data),
    .rxb_last(rxb_last), .tx_req(tx_req), .rx_req(rx_req),
    .tx_ovf(tx_ovf), .rx_unf(rx_unf)
  );

  int total = 0, bad = 0;
  bit finished = 0;

  // reference model state
  logic [31:0] txq[$], rxq[$];
  bit          tfl, rfl, held, m_ovf, m_unf;
  logic [2:0]  ttr, rtr;
  logic [31:0] hword, acc;
  int          idx, nb;
  logic [7:0]  got[$];
  bit          seen_ovf;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    int tsz, rsz;
    bit ctrlw, rdy, tf0, rf0;
    logic [31:0] merged;
    if (!rst_n) begin
      txq.delete(); rxq.delete();
      tfl = 0; rfl = 0; held = 0; m_ovf = 0; m_unf = 0;
      ttr = 0; rtr = 0; hword = 0; acc = 0; idx = 0; nb = 0;
    end else begin
      tsz = txq.size(); rsz = rxq.size();
      ctrlw = bus_wr && bus_addr == 2'd0;
      rdy = !rfl && rsz < DEPTH;
      tf0 = tfl; rf0 = rfl;
      m_ovf = bus_wr && bus_addr == 2'd2 && !tf0 && tsz == DEPTH;
      m_unf = bus_rd && bus_addr == 2'd3 && !rf0 && rsz == 0;
      if (tf0) begin
        held = 0;
        if (tsz > 0) void'(txq.pop_front());
      end else begin
        if (held) begin
          if (txb_ready) begin
            if (idx == 3) held = 0;
            idx = (idx + 1) % 4;
          end
        end else if (tsz > 0) begin
          hword = txq.pop_front(); held = 1; idx = 0;
        end
        if (bus_wr && bus_addr == 2'd2 && tsz < DEPTH) txq.push_back(bus_wdata);
      end
      if (ctrlw && bus_wdata[1]) tfl = 1;
      else if (tf0 && tsz == 0) tfl = 0;
      if (rf0) begin
        nb = 0; acc = 0;
        if (rsz > 0) void'(rxq.pop_front());
      end else begin
        if (bus_rd && bus_addr == 2'd3 && rsz > 0) void'(rxq.pop_front());
        if (rxb_valid && rdy) begin
          merged = acc | (32'(rxb_data) << (8 * nb));
          if (nb == 3 || rxb_last) begin
            rxq.push_back(merged); nb = 0; acc = 0;
          end else begin
            acc = merged; nb++;
          end
        end
      end
      if (ctrlw && bus_wdata[0]) rfl = 1;
      else if (rf0 && rsz == 0) rfl = 0;
      if (ctrlw) begin ttr = bus_wdata[7:5]; rtr = bus_wdata[4:2]; end
    end
  end

  // compare every cycle, inputs settled at negedge+1
  always @(negedge clk) begin
    int tfree, rcnt;
    logic [31:0] er;
    string tg;
    #3;
    if (rst_n && !finished) begin
      tfree = DEPTH - txq.size(); rcnt = rxq.size();
      case (bus_addr)
        2'd0: begin er = {24'b0, ttr, rtr, tfl, rfl}; tg = "R2 R8 ctrl"; end
        2'd1: begin er = {24'b0, 4'(tfree), 4'(rcnt)}; tg = "R3 status"; end
        2'd2: begin er = 0; tg = "R2 txd"; end
        default: begin
          er = (rfl || rcnt == 0) ? 32'h0 : rxq[0];
          tg = rfl ? "R9 rxd" : (rcnt == 0 ? "R7 rxd" : "R5 rxd");
        end
      endcase
      chk(tg, bus_rdata, er);
      chk(tfl ? "R9 txb_valid" : "R4 txb_valid", 32'(txb_valid), 32'(held && !tfl));
      if (held && !tfl) chk("R4 txb_data", 32'(txb_data), 32'(hword[8*idx +: 8]));
      chk("R6 rxb_ready", 32'(rxb_ready), 32'(!rfl && rcnt < DEPTH));
      chk("R10 tx_req", 32'(tx_req), 32'(tfree >= int'(ttr) + 1));
      chk("R10 rx_req", 32'(rx_req), 32'(rcnt >= int'(rtr) + 1));
      chk("R3 tx_ovf", 32'(tx_ovf), 32'(m_ovf));
      chk("R7 rx_unf", 32'(rx_unf), 32'(m_unf));
      if (txb_valid && txb_ready) got.push_back(txb_data);
      if (tx_ovf) seen_ovf = 1;
    end
  end

  task automatic op(input bit w, input bit r, input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) op(0, 0, bus_addr, 0);
  endtask

  task automatic rx_bytes(input int len, input logic [7:0] base);
    for (int i = 0; i < len; i++) begin
      @(negedge clk); #1;
      bus_wr = 0; bus_rd = 0;
      rxb_valid = 1; rxb_data = base + 8'(i); rxb_last = (i == len - 1);
      #1;
      while (!rxb_ready) begin @(negedge clk); #2; end
    end
    @(negedge clk); #1; rxb_valid = 0; rxb_last = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1; total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    // R1 reset state
    op(0, 0, 2'd1, 0); #2; chk("R1 status after reset", bus_rdata, 32'h80);
    op(0, 0, 2'd0, 0); #2; chk("R1 ctrl after reset", bus_rdata, 32'h0);
    // R4 byte order, engine always ready
    txb_ready = 1; got.delete();
    op(1, 0, 2'd2, 32'h44332211);
    op(1, 0, 2'd2, 32'h88776655);
    idle(14);
    chk("R4 byte count", got.size(), 8);
    for (int i = 0; i < 8 && i < got.size(); i++)
      chk("R4 byte order", 32'(got[i]), 32'(8'h11 * (i + 1)));
    // R3 overflow with engine stalled
    txb_ready = 0; seen_ovf = 0;
    for (int i = 0; i < 11; i++) op(1, 0, 2'd2, 32'hA0000000 + i);
    op(0, 0, 2'd1, 0); #2;
    chk("R3 full status", bus_rdata, 32'h00);
    chk("R3 overflow seen", 32'(seen_ovf), 1);
    // R8 R9 transmit flush, with a write during it
    op(1, 0, 2'd0, 32'h2);
    op(0, 0, 2'd0, 0); #2; chk("R8 tx flush bit held", bus_rdata[1], 1);
    seen_ovf = 0;
    op(1, 0, 2'd2, 32'hDEAD);
    idle(12);
    op(0, 0, 2'd0, 0); #2; chk("R8 tx flush bit cleared", bus_rdata[1], 0);
    op(0, 0, 2'd1, 0); #2; chk("R9 status after tx flush", bus_rdata, 32'h80);
    chk("R9 no ovf in flush", 32'(seen_ovf), 0);
    // R5 packing with partial last words
    rx_bytes(1, 8'hA1);
    rx_bytes(3, 8'hB1);
    rx_bytes(6, 8'hC1);
    op(0, 1, 2'd3, 0); #2; chk("R5 one-byte word", bus_rdata, 32'h000000A1);
    op(0, 1, 2'd3, 0); #2; chk("R5 three-byte word", bus_rdata, 32'h00B3B2B1);
    op(0, 1, 2'd3, 0);
    op(0, 1, 2'd3, 0); #2; chk("R5 two-byte tail", bus_rdata, 32'h0000C6C5);
    op(0, 1, 2'd3, 0); #2; chk("R7 empty read", bus_rdata, 32'h0);
    op(0, 0, 2'd1, 0); #2; chk("R7 unf pulse", 32'(rx_unf), 1);
    // R6 fill receive FIFO
    for (int i = 0; i < 8; i++) rx_bytes(4, 8'(i * 16));
    @(negedge clk); #1; rxb_valid = 1; rxb_data = 8'h55; #2;
    chk("R6 ready low when full", 32'(rxb_ready), 0);
    @(negedge clk); #1; rxb_valid = 0;
    // R8 R9 receive flush with a read during it
    op(1, 0, 2'd0, 32'h1);
    op(0, 1, 2'd3, 0); #2; chk("R9 read during rx flush", bus_rdata, 32'h0);
    idle(12);
    op(0, 0, 2'd1, 0); #2; chk("R8 rx empty after flush", bus_rdata, 32'h80);
    // R10 trigger codes 7 (tx) and 0 (rx)
    op(1, 0, 2'd0, 32'hE0);
    op(1, 0, 2'd2, 32'h1);
    op(1, 0, 2'd2, 32'h2);
    idle(2); #2; chk("R10 tx_req off at 7 free", 32'(tx_req), 0);
    rx_bytes(1, 8'h01); #2; chk("R10 rx_req on at 1 word", 32'(rx_req), 1);
    op(1, 0, 2'd0, 32'h3);
    idle(12);
    // random mixed traffic
    for (int c = 0; c < 6000; c++) begin
      int r;
      @(negedge clk); #1;
      r = $urandom % 16;
      bus_wr = 0; bus_rd = 0; bus_wdata = $urandom;
      if (r < 4) begin bus_wr = 1; bus_addr = 2'd2; end
      else if (r < 7) begin bus_rd = 1; bus_addr = 2'd3; end
      else if (r == 7) begin bus_addr = 2'd1; end
      else if (r == 8) begin
        bus_wr = 1; bus_addr = 2'd0;
        if ($urandom % 4 != 0) bus_wdata[1:0] = 2'b00;
      end else bus_addr = 2'($urandom % 4);
      txb_ready = ($urandom % 3) != 0;
      rxb_valid = ($urandom % 2) != 0;
      rxb_data = 8'($urandom);
      rxb_last = ($urandom % 5) == 0;
    end
    op(0, 0, 2'd0, 0); rxb_valid = 0;
    idle(4);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule